// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block produces one pulse-width-modulated output from an oscillator clock. Two 32-bit registers control it. The first is a control word holding a prescaler code, an enable, an active-level bit and a clock gate. The second is a timing word holding a 16-bit period and a 16-bit duty.

The prescaler code selects a divider from a fixed table that is not a set of powers of two. Some codes are reserved, and one code passes the oscillator through undivided. Each prescaled tick advances a 16-bit counter, which wraps after the programmed number of ticks. The output takes its active level while the counter is below the duty value.

Software changes the prescaler with a fixed sequence: close the gate, write the code, then open the gate again. New timing values wait in a shadow register until the current cycle completes, so a rewrite never produces a truncated pulse.

Top module: `pwm_prescaled`

## Requirements
- R1: Register map and readback. `bus_addr[2]`=0 selects the control word and `bus_addr[2]`=1 selects the timing word.
  - Control word fields: prescaler code in [3:0], enable in bit 4, active level in bit 5, gate in bit 6. Bits [31:7] read as 0.
  - Timing word fields: period in [31:16], duty in [15:0].
  - Reads return the stored values combinationally.
- R2: The prescaler codes select these dividers:
  - 0 to 4 select 120, 180, 240, 360 and 480.
  - 8 to 12 select 12000, 24000, 36000, 48000 and 72000.
  - 15 selects divide-by-1.
  - The counter advances once every divider-many clock cycles.
- R3: A control write made while the stored gate bit is 1 leaves the prescaler code unchanged. Readback and output timing both keep the previous divider.
- R4: Codes 5, 6, 7, 13 and 14 are reserved. With such a code, enable=1 and gate=1, no tick occurs and the counter holds its value.
- R5: The period is the number of ticks per output cycle, and a period of 0 behaves as 1. The counter wraps to 0 after the count reaches period-1.
- R6: The output is active while the counter is below duty. A duty of 0 gives a constant inactive output. A duty at or above the period gives a constant active output.
- R7: Active-level bit = 1 drives the active portion high. Active-level bit = 0 inverts it: the active portion is low and the inactive level is high.
- R8: When enable=0 or gate=0, the output sits at the inactive level and the counter and prescaler return to 0. The next start begins at phase 0.
- R9: A timing-word write while running takes effect at the next counter wrap. While stopped, it takes effect immediately.
- R10: After reset both registers read 0 and `pwm_out` is 1, which is the inactive level for active-level bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address; bit 2 picks the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
The bench compares the output, cycle by cycle, against patterns that it works out from period, duty, divider and level. This exposes an off-by-one in the wrap or the compare, which would stretch or clip every pulse.

It tests several timing edge cases:
- A period of 0, a duty of 0 and a duty above the period, where a design would lose the output or leave it toggling.
- A timing rewrite in the middle of a cycle, where a design without the shadow would cut the running pulse short.

It also tests the prescaler paths:
- A code change while the gate is open, which a faulty design would accept.
- A reserved code, where a faulty design would keep counting at a stray divider.
- Divider values from the table, where a wrong entry shifts the pulse edges.

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
  parameter int CW  = 16,
  parameter int PSW = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);

  function automatic logic [PSW-1:0] div_of(input logic [3:0] c);
    case (c)
      4'd0:    div_of = PSW'(120);
      4'd1:    div_of = PSW'(180);
      4'd2:    div_of = PSW'(240);
      4'd3:    div_of = PSW'(360);
      4'd4:    div_of = PSW'(480);
      4'd8:    div_of = PSW'(12000);
      4'd9:    div_of = PSW'(24000);
      4'd10:   div_of = PSW'(36000);
      4'd11:   div_of = PSW'(48000);
      4'd12:   div_of = PSW'(72000);
      4'd15:   div_of = PSW'(1);
      default: div_of = '0;
    endcase
  endfunction

  logic [3:0]     code;
  logic           en, act, gate;
  logic [CW-1:0]  per_p, duty_p, per_a, duty_a, cnt;
  logic [PSW-1:0] pcnt;

  wire            ctrl_wr = bus_wr & ~bus_addr[2];
  wire            tim_wr  = bus_wr &  bus_addr[2];
  wire            run     = en & gate;
  wire [PSW-1:0]  div     = div_of(code);
  wire            valid   = div != '0;
  wire            tick    = run & valid & (pcnt == div - 1'b1);
  wire [CW-1:0]   per_eff = (per_a == '0) ? CW'(1) : per_a;
  wire            wrap    = tick & (cnt >= per_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0; en <= 1'b0; act <= 1'b0; gate <= 1'b0;
    end else if (ctrl_wr) begin
      en   <= bus_wdata[4];
      act  <= bus_wdata[5];
      gate <= bus_wdata[6];
      if (!gate) code <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_p <= '0; duty_p <= '0;
    end else if (tim_wr) begin
      per_p  <= bus_wdata[16 +: CW];
      duty_p <= bus_wdata[0 +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a <= '0; duty_a <= '0;
    end else if (!run || wrap) begin
      per_a  <= per_p;
      duty_a <= duty_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run || !valid) pcnt <= '0;
    else if (tick)           pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign pwm_out   = (run && cnt < duty_a) ? act : ~act;
  assign bus_rdata = bus_addr[2] ? {16'(per_p), 16'(duty_p)}
                                 : {25'd0, gate, act, en, code};

  a_r3_code_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && gate) |=> $stable(code));

  a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !valid) |=> $stable(cnt));

  a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_eff));

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && pcnt == '0));

  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(per_a) && $stable(duty_a)));

endmodule

// File: tb/sim_pwm_prescaled.sv
module sim_pwm_prescaled;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  pwm_prescaled u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  typedef struct { logic v; string tag; } item_t;
  item_t q[$];
  item_t it;
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] a, logic [31:0] e);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(pwm_out === it.v, it.tag, {31'd0, pwm_out}, {31'd0, it.v});
    end
  end

  function automatic logic ex(int j, int per, int duty, logic a, int div);
    int p = (per == 0) ? 1 : per;
    int c = (j / div) % p;
    return (c < duty) ? a : ~a;
  endfunction

  task automatic push(int n, int j0, int per, int duty, logic a, int div, string tag);
    for (int j = j0; j < j0 + n; j++) begin
      item_t x;
      x.v = ex(j, per, duty, a, div);
      x.tag = tag;
      q.push_back(x);
    end
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata === e, tag, bus_rdata, e);
  endtask

  task automatic restart(int per, int duty, logic [31:0] ctrl);
    wr(3'd0, ctrl & ~32'h10);
    wr(3'd4, {16'(per), 16'(duty)});
    wr(3'd0, ctrl);
  endtask

  task automatic seq_code(logic [3:0] c, int per, int duty, int div, int n, string tag);
    wr(3'd0, 32'h30 | 32'(c));
    push(3, 0, 1, 0, 1'b1, 1, "R8 gate off");
    drain();
    wr(3'd0, 32'h30 | 32'(c));
    wr(3'd4, {16'(per), 16'(duty)});
    wr(3'd0, 32'h70 | 32'(c));
    push(n, 0, per, duty, 1'b1, div, tag);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pwm_out === 1'b1, "R10 reset output", {31'd0, pwm_out}, 32'd1);
    rd(3'd0, 32'h0, "R10 ctrl reset");
    rd(3'd4, 32'h0, "R10 timing reset");

    wr(3'd0, 32'hFFFF_FF8F);
    rd(3'd0, 32'h0000_000F, "R1 ctrl unused bits");
    wr(3'd4, 32'h0005_0002);
    rd(3'd4, 32'h0005_0002, "R1 timing readback");

    restart(5, 2, 32'h7F);
    push(20, 0, 5, 2, 1'b1, 1, "R6 per5 duty2");
    drain();

    wr(3'd0, 32'h6F);
    push(5, 0, 1, 0, 1'b1, 1, "R8 disabled");
    drain();

    restart(4, 1, 32'h5F);
    push(16, 0, 4, 1, 1'b0, 1, "R7 inverted");
    drain();

    restart(3, 0, 32'h7F);
    push(12, 0, 3, 0, 1'b1, 1, "R6 duty zero");
    drain();
    restart(3, 5, 32'h7F);
    push(12, 0, 3, 5, 1'b1, 1, "R6 duty above period");
    drain();
    restart(0, 1, 32'h7F);
    push(8, 0, 0, 1, 1'b1, 1, "R5 period zero");
    drain();

    restart(4, 2, 32'h7F);
    push(2, 0, 4, 2, 1'b1, 1, "R9 before rewrite");
    drain();
    wr(3'd4, {16'd6, 16'd3});
    push(1, 3, 4, 2, 1'b1, 1, "R9 old until wrap");
    push(12, 0, 6, 3, 1'b1, 1, "R9 new after wrap");
    drain();

    restart(4, 2, 32'h70);
    rd(3'd0, 32'h7F, "R3 code locked");
    push(12, 1, 4, 2, 1'b1, 1, "R3 divider kept");
    drain();

    seq_code(4'd0, 2, 1, 120, 480, "R2 divide 120");
    rd(3'd0, 32'h70, "R2 code 0 readback");
    seq_code(4'd1, 2, 1, 180, 400, "R2 divide 180");
    seq_code(4'd5, 2, 1, 1 << 30, 20, "R4 reserved holds");
    rd(3'd0, 32'h75, "R4 code 5 readback");
    seq_code(4'd15, 3, 2, 1, 12, "R8 restart phase");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule